// File: doc/BRIEF.md
# Serial Link Idle Stub

This block stands in for a byte-wide serial link port on a system where no partner device is ever attached. Software sees two byte registers on a simple read/write bus: a data register and a control register. Writing the control register with its start bit (bit 7) set arms a countdown. While the countdown is armed it drops by a per-cycle tick amount supplied by the system timebase. When it runs out, the block behaves as if a full byte of ones had arrived from an idle line. The data register becomes 0xFF, the start bit clears, and a one-cycle interrupt request pulse goes out.

No bits are actually shifted, so the block has no pins toward a link. The full countdown loaded on a control write is the sum of two parameters, `IDLE_CYCLES` and `XFER_CYCLES`. After an expiry the countdown reloads `IDLE_CYCLES` alone, and after reset it holds `XFER_CYCLES`. Both of these loads are internal and are overwritten by the next control write. The register bus is a plain control path with no handshake. A write takes effect on the clock edge where `wr_en` is high. A read returns combinationally on `rdata` for whatever `addr` presents, and there is no back-pressure on either path.

Top module: `ser_idle_stub`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x00 and `irq_pulse` is low.
- R2: `rdata` shows the data register when `addr` equals `DATA_ADDR` (0xFF01), shows the control register when `addr` equals `CTRL_ADDR` (0xFF02), and shows 0xFF for any other address.
- R3: A bus write to `DATA_ADDR` stores the written byte, provided no expiry happens in the same cycle.
- R4: A bus write to `CTRL_ADDR` stores all eight bits. It also reloads the countdown to `IDLE_CYCLES + XFER_CYCLES`, even if a countdown is already running. A control write in the same cycle as a would-be expiry suppresses that expiry.
- R5: While control bit 7 is set, each cycle subtracts `tick` from the countdown. Expiry happens in the cycle where `tick` is greater than or equal to the remaining count. With a constant tick t after a control write, expiry therefore comes ceil((IDLE_CYCLES+XFER_CYCLES)/t) cycles later.
- R6: On expiry the data register becomes 0xFF, control bit 7 clears while bits 6..0 keep their value, and the countdown reloads `IDLE_CYCLES`.
- R7: `irq_pulse` is high for exactly the one cycle that follows the clock edge on which an expiry updates the registers.
- R8: While control bit 7 is clear, the countdown is frozen. No tick value then changes the data register or produces `irq_pulse`.
- R9: When a data write coincides with an expiry, the expiry wins and the data register reads 0xFF afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick | input | TICK_W | Countdown decrement applied this cycle |
| irq_pulse | output | 1 | One-cycle transfer-complete interrupt request |

## Verification
The bench sweeps every non-zero tick value against several control bytes and measures the cycle distance from the control write to the interrupt. A design that compared with strict greater-than, or that subtracted once too often, would land one cycle early or late on the tick values that divide the full period exactly. The bench also goes after collisions. A control write on the expiry cycle must suppress the interrupt, and a design that let the countdown win would pulse anyway. A data write on the expiry cycle must lose, and a design with the wrong order would leave the written byte in place of 0xFF. It further checks a restart mid-countdown, which a design that did not reload would finish early, and a long run with bit 7 clear, where a design that ignored the arm bit would raise spurious interrupts.

// File: rtl/ser_stub_pkg.sv
package ser_stub_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t IDLE_LINE_BYTE = 8'hFF;
  localparam byte_t UNMAPPED_READ  = 8'hFF;
  localparam int    START_BIT      = 7;
endpackage

// File: rtl/ser_stub_regs.sv
module ser_stub_regs
  import ser_stub_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] DATA_ADDR = 16'hFF01,
  parameter logic [15:0] CTRL_ADDR = 16'hFF02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  input  logic              expire,
  output byte_t             rdata,
  output logic              ctrl_wr,
  output logic              armed
);
  localparam logic [ADDR_W-1:0] DATA_SEL = DATA_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CTRL_SEL = CTRL_ADDR[ADDR_W-1:0];

  byte_t data_q;
  byte_t ctrl_q;
  logic  data_wr;

  assign data_wr = wr_en && (addr == DATA_SEL);
  assign ctrl_wr = wr_en && (addr == CTRL_SEL);
  assign armed   = ctrl_q[START_BIT];

  // Expiry overrides a simultaneous data write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (expire) begin
      data_q <= IDLE_LINE_BYTE;
    end else if (data_wr) begin
      data_q <= wdata;
    end
  end

  // A control write takes priority; expiry only drops the start bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata;
    end else if (expire) begin
      ctrl_q[START_BIT] <= 1'b0;
    end
  end

  always_comb begin
    if (addr == DATA_SEL) begin
      rdata = data_q;
    end else if (addr == CTRL_SEL) begin
      rdata = ctrl_q;
    end else begin
      rdata = UNMAPPED_READ;
    end
  end

  a_r6_expiry_forces_regs: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (data_q == IDLE_LINE_BYTE) && !ctrl_q[START_BIT]);

  a_r9_expiry_beats_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && data_wr) |=> (data_q == IDLE_LINE_BYTE));

  a_r4_ctrl_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == $past(wdata)));

  a_r8_disarmed_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !data_wr) |=> $stable(data_q));
endmodule

// File: rtl/ser_stub_countdown.sv
module ser_stub_countdown #(
  parameter int XFER_CYCLES = 512,
  parameter int IDLE_CYCLES = 128,
  parameter int TICK_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              armed,
  input  logic [TICK_W-1:0] tick,
  output logic              expire
);
  localparam int FULL_CYCLES = XFER_CYCLES + IDLE_CYCLES;
  localparam int CNT_RAW     = $clog2(FULL_CYCLES + 1);
  localparam int CW          = (CNT_RAW > TICK_W) ? CNT_RAW : TICK_W;
  localparam logic [CW-1:0] FULL_LOAD = CW'(FULL_CYCLES);
  localparam logic [CW-1:0] IDLE_LOAD = CW'(IDLE_CYCLES);
  localparam logic [CW-1:0] XFER_LOAD = CW'(XFER_CYCLES);

  logic [CW-1:0] remain_q;
  logic [CW-1:0] tick_ext;

  assign tick_ext = CW'(tick);
  // Expiry when this tick brings the count to zero or below.
  assign expire   = armed && !load && (tick_ext >= remain_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= XFER_LOAD;
    end else if (load) begin
      remain_q <= FULL_LOAD;
    end else if (expire) begin
      remain_q <= IDLE_LOAD;
    end else if (armed) begin
      remain_q <= remain_q - tick_ext;
    end
  end

  a_r4_full_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (remain_q == FULL_LOAD));

  a_r6_idle_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (remain_q == IDLE_LOAD));

  a_r8_frozen_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> $stable(remain_q));

  a_r5_never_hits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (remain_q != '0));
endmodule

// File: rtl/ser_stub_irq.sv
module ser_stub_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic irq_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= expire;
    end
  end

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r7_follows_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_pulse);
endmodule

// File: rtl/ser_idle_stub.sv
module ser_idle_stub
  import ser_stub_pkg::*;
#(
  parameter int          XFER_CYCLES = 512,
  parameter int          IDLE_CYCLES = 128,
  parameter int          TICK_W      = 4,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] DATA_ADDR   = 16'hFF01,
  parameter logic [15:0] CTRL_ADDR   = 16'hFF02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [TICK_W-1:0] tick,
  output logic              irq_pulse
);
  logic ctrl_wr;
  logic armed;
  logic expire;

  ser_stub_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_ADDR(DATA_ADDR),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .expire (expire),
    .rdata  (rdata),
    .ctrl_wr(ctrl_wr),
    .armed  (armed)
  );

  ser_stub_countdown #(
    .XFER_CYCLES(XFER_CYCLES),
    .IDLE_CYCLES(IDLE_CYCLES),
    .TICK_W     (TICK_W)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ctrl_wr),
    .armed (armed),
    .tick  (tick),
    .expire(expire)
  );

  ser_stub_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .irq_pulse(irq_pulse)
  );

  a_r7_irq_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(armed));
endmodule

// File: tb/ser_idle_stub_tb.sv
`timescale 1ns/1ps
module ser_idle_stub_tb;
  localparam int XFER = 20;
  localparam int IDLE = 12;
  localparam int FULL = XFER + IDLE;
  localparam int TW   = 3;
  localparam logic [15:0] DA = 16'hFF01;
  localparam logic [15:0] CA = 16'hFF02;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   addr = 16'h0000;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;
  logic [TW-1:0] tick = '0;
  logic          irq_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the requirements.
  logic [7:0] m_data;
  logic [7:0] m_ctrl;
  int         m_cnt;
  bit         last_irq;

  always #4 clk = ~clk;

  ser_idle_stub #(
    .XFER_CYCLES(XFER),
    .IDLE_CYCLES(IDLE),
    .TICK_W     (TW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .irq_pulse(irq_pulse)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit w, logic [15:0] a, logic [7:0] d, int t);
    bit e_exp;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick = TW'(t);
    e_exp = 1'b0;
    if (w && a == CA) begin
      m_ctrl = d; m_cnt = FULL;
    end else begin
      if (m_ctrl[7]) begin
        if (t >= m_cnt) begin
          e_exp = 1'b1; m_cnt = IDLE; m_ctrl[7] = 1'b0; m_data = 8'hFF;
        end else begin
          m_cnt = m_cnt - t;
        end
      end
      if (w && a == DA && !e_exp) m_data = d;
    end
    @(posedge clk); #1;
    last_irq = irq_pulse;
    chk(tag, irq_pulse, e_exp);
    wr_en = 1'b0; tick = '0;
  endtask

  task automatic rd(string tag, logic [15:0] a, int exp);
    wr_en = 1'b0; tick = '0; addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic model_regs(string tag);
    rd(tag, DA, m_data);
    rd(tag, CA, m_ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_data = 8'h00; m_ctrl = 8'h00; m_cnt = XFER;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", irq_pulse, 0);
    rd("R1 data", DA, 8'h00);
    rd("R1 ctrl", CA, 8'h00);
    rst_n = 1'b1;
    // R2 unmapped reads
    rd("R2 unmapped 0000", 16'h0000, 8'hFF);
    rd("R2 unmapped FF00", 16'hFF00, 8'hFF);
    rd("R2 unmapped FF03", 16'hFF03, 8'hFF);
    // R3 data write
    step("R3", 1, DA, 8'h5A, 0);
    rd("R3 data", DA, 8'h5A);
    step("R3", 1, 16'hFF05, 8'h11, 0);
    rd("R2 write elsewhere", DA, 8'h5A);
    // R8 disarmed control: frozen
    step("R4", 1, CA, 8'h12, 0);
    rd("R4 ctrl stored", CA, 8'h12);
    for (int i = 0; i < 60; i++) step("R8 no irq", 0, 16'h0, 8'h0, 7);
    rd("R8 data kept", DA, 8'h5A);
    rd("R8 ctrl kept", CA, 8'h12);

    // R5/R6/R7 sweep of tick values and control bytes
    for (int t = 1; t < (1 << TW); t++) begin
      for (int v = 0; v < 3; v++) begin
        logic [7:0] cv;
        int n;
        int seen;
        cv = (v == 0) ? 8'h80 : (v == 1) ? 8'h81 : 8'hFE;
        step("R3", 1, DA, 8'(t * 16 + v), 0);
        step("R4", 1, CA, cv, 0);
        n = 0; seen = 0;
        while (seen == 0 && n < FULL + 4) begin
          step("R7 pulse timing", 0, 16'h0, 8'h0, t);
          n++;
          if (last_irq) seen = n;
        end
        chk("R5 expiry distance", seen, (FULL + t - 1) / t);
        step("R7 single cycle", 0, 16'h0, 8'h0, t);
        rd("R6 data ones", DA, 8'hFF);
        rd("R6 ctrl bit7 cleared", CA, cv & 8'h7F);
      end
    end

    // Mixed tick pattern with model
    step("R4", 1, CA, 8'h83, 0);
    for (int i = 0; i < 40; i++) begin
      step("R5 mixed ticks", 0, 16'h0, 8'h0, (i * 3) % 8);
      model_regs("R5 mixed regs");
    end

    // R4 restart mid-countdown
    step("R4", 1, CA, 8'h80, 0);
    for (int i = 0; i < 10; i++) step("R4 partial", 0, 16'h0, 8'h0, 2);
    step("R4 restart", 1, CA, 8'h80, 0);
    begin
      int n;
      n = 0;
      last_irq = 1'b0;
      while (!last_irq && n < 40) begin
        step("R4 after restart", 0, 16'h0, 8'h0, 4);
        n++;
      end
      chk("R4 restart distance", n, FULL / 4);
    end

    // R4 control write on the would-be expiry cycle
    step("R4", 1, CA, 8'h80, 0);
    for (int i = 0; i < 4; i++) step("R4 pre", 0, 16'h0, 8'h0, 7);
    step("R4 collide no irq", 1, CA, 8'h84, 7);
    rd("R4 collide ctrl", CA, 8'h84);
    for (int i = 0; i < 4; i++) step("R4 post", 0, 16'h0, 8'h0, 7);
    step("R7 irq after collide", 0, 16'h0, 8'h0, 7);
    chk("R4 full reload after collide", last_irq, 1);

    // R9 data write on the expiry cycle
    step("R3", 1, DA, 8'h33, 0);
    step("R4", 1, CA, 8'h80, 0);
    for (int i = 0; i < 4; i++) step("R9 pre", 0, 16'h0, 8'h0, 7);
    step("R9 collide", 1, DA, 8'h44, 7);
    chk("R9 irq", last_irq, 1);
    rd("R9 data wins ones", DA, 8'hFF);

    // R3 data write while armed is kept until expiry
    step("R4", 1, CA, 8'h80, 0);
    step("R3 armed write", 1, DA, 8'h27, 1);
    rd("R3 armed data", DA, 8'h27);
    model_regs("R3 model");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule